// File: doc/BRIEF.md
# Shared Issue Queue Capacity Allocator

This block decides how many issue-queue entries each of up to four hardware threads may hold. It does not store instructions. It tracks how many entries each thread holds now, using three kinds of event: an insert, a release when an instruction issues, and a release when an instruction is squashed. It also keeps one global free-entry counter for the whole queue. From these it reports, for each thread, how much room is left and whether the thread is full, and it reports whether the queue as a whole is full. An insert that would overflow is dropped and flagged.

A static policy input chooses how capacity is shared:

- **Dynamic:** every thread may use the whole queue.
- **Partitioned:** the queue is split evenly between the threads.
- **Threshold:** each thread is capped at a percentage of the queue.

When the active-thread mask changes, the limits are rebalanced.

A small state machine sequences the limit updates. It has three states:

- **ST_INIT** is entered on reset. It loads the base limits, then takes the transition *init_done* to ST_RUN.
- **ST_RUN** counts events. It takes the transition *mask_changed* to ST_REBAL when the active mask differs from the mask last latched.
- **ST_REBAL** loads limits computed for the current mask. It takes the transition *rebal_done* back to ST_RUN.

Top module: `iqa_alloc`

## Requirements
- R1: While reset is held, every thread limit is 0, so each thread reports free 0 and full 1, `q_full` is 0 and `ovf_err` is 0. The first clock edge after reset (ST_INIT) loads the base limits, and they are visible after that edge.
- R2: `policy_sel` 2'b00 (dynamic) gives every thread the limit TOTAL. Code 2'b11 behaves the same as 2'b00.
- R3: `policy_sel` 2'b01 (partitioned) gives each thread the base limit TOTAL/NT, rounded down.
- R4: `policy_sel` 2'b10 (threshold) gives each thread the base limit TOTAL*p/100, truncated. Here p is `thr_pct`, clamped to 100.
- R5: A change of `active_mask` seen in ST_RUN moves the machine to ST_REBAL at that edge. The new limits are loaded at the next edge, so they are visible two edges after the new mask is first sampled.
- R6: During a partitioned rebalance, each thread whose mask bit is set gets TOTAL/(number of set bits). Threads whose bit is clear get the base limit. An all-zero mask restores the base limit for every thread.
- R7: During a threshold rebalance with exactly one mask bit set, that thread gets TOTAL. Every other thread, and every thread when more than one bit is set, gets the base threshold limit.
- R8: A thread's free count is its limit minus its count, and it saturates at 0 when a rebalance shrinks the limit below the count. The thread's full flag is 1 exactly when its free count is 0.
- R9: `q_full` is 1 when the global free counter is 0. That counter always equals TOTAL minus the sum of the per-thread counts.
- R10: An insert is accepted only if its thread is not full and `q_full` is 0. An accepted insert raises that thread's count by one. A rejected insert changes no count and drives `ovf_err` high for exactly the one cycle after the edge that sampled it.
- R11: An issue release and a squash release each lower the count of the thread they name by one. Both naming the same thread in one cycle lower it by two, limited to the current count. A release aimed at a thread whose count is 0 is ignored.
- R12: An accepted insert and one release for the same thread in the same cycle leave that thread's count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| policy_sel | input | 2 | Sharing policy: 00 dynamic, 01 partitioned, 10 threshold, 11 dynamic |
| thr_pct | input | 7 | Threshold percentage (clamped to 100) |
| active_mask | input | NT | One bit per active thread |
| ins_vld | input | 1 | Insert request |
| ins_tid | input | TW | Thread of the insert |
| rel_vld | input | 1 | Issue release |
| rel_tid | input | TW | Thread of the issue release |
| sqr_vld | input | 1 | Squash release |
| sqr_tid | input | TW | Thread of the squash release |
| thr_free | output | NT*CW | Free count per thread; thread t occupies bits [t*CW +: CW] |
| thr_full | output | NT | Full flag per thread |
| q_full | output | 1 | Global free counter is zero |
| ovf_err | output | 1 | One-cycle pulse for a rejected insert |

## Verification
Count and free-counter changes caused by an insert or a release are due right after the clock edge that samples the event. The per-thread free counts, the full flags and `ovf_err` therefore appear one edge later. A changed active mask needs two edges: one edge to enter ST_REBAL and one to load the new limits. The bench drives every input on the falling edge and steps one or two rising edges, as the event requires. It samples on the following falling edge, so every comparison is made in the cycle where the result is first due.

// File: rtl/iqa_pkg.sv
package iqa_pkg;
    typedef enum logic [1:0] {
        POL_DYN  = 2'b00,
        POL_PART = 2'b01,
        POL_THR  = 2'b10,
        POL_DYN2 = 2'b11
    } policy_e;

    typedef enum logic [1:0] {
        ST_INIT  = 2'b00,
        ST_RUN   = 2'b01,
        ST_REBAL = 2'b10
    } alloc_state_e;
endpackage

// File: rtl/iqa_limit_calc.sv
module iqa_limit_calc
    import iqa_pkg::*;
#(
    parameter int NT    = 4,
    parameter int TOTAL = 32,
    parameter int CW    = $clog2(TOTAL + 1)
) (
    input  logic [1:0]       policy,
    input  logic [6:0]       pct,
    input  logic [NT-1:0]    mask,
    input  logic             use_mask,
    output logic [NT*CW-1:0] lim_flat
);
    localparam int PW = CW + 8;
    localparam int NW = $clog2(NT + 1);
    localparam logic [CW-1:0] TOT_C  = CW'(TOTAL);
    localparam logic [CW-1:0] PART_C = CW'(TOTAL / NT);

    logic [NW-1:0] nact;
    logic [6:0]    pct_c;
    logic [PW-1:0] prod;
    logic [CW-1:0] thr_base;
    logic [CW-1:0] part_share;

    always_comb begin
        nact = '0;
        for (int i = 0; i < NT; i++) begin
            nact = nact + NW'(mask[i]);
        end
        pct_c      = (pct > 7'd100) ? 7'd100 : pct;
        prod       = PW'(TOTAL) * PW'(pct_c);
        thr_base   = CW'(prod / PW'(100));
        part_share = (nact != '0) ? CW'(TOT_C / CW'(nact)) : PART_C;
    end

    for (genvar t = 0; t < NT; t++) begin : g_lim
        always_comb begin
            unique case (policy_e'(policy))
                POL_PART:
                    lim_flat[t*CW +: CW] = (use_mask && mask[t]) ? part_share : PART_C;
                POL_THR:
                    lim_flat[t*CW +: CW] = (use_mask && mask[t] && nact == NW'(1)) ? TOT_C : thr_base;
                default:
                    lim_flat[t*CW +: CW] = TOT_C;
            endcase
        end
    end
endmodule

// File: rtl/iqa_thread_ctr.sv
module iqa_thread_ctr #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] limit,
    input  logic          inc,
    input  logic          rel,
    input  logic          sqr,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] free,
    output logic          full,
    output logic [1:0]    dec_taken
);
    logic [1:0] dec_req;

    always_comb begin
        dec_req   = {1'b0, rel} + {1'b0, sqr};
        dec_taken = (cnt >= CW'(dec_req)) ? dec_req : cnt[1:0];
        free      = (limit > cnt) ? (limit - cnt) : '0;
        full      = (free == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + CW'(inc) - CW'(dec_taken);
    end
endmodule

// File: rtl/iqa_alloc.sv
module iqa_alloc
    import iqa_pkg::*;
#(
    parameter int NT    = 4,
    parameter int TOTAL = 32,
    parameter int CW    = $clog2(TOTAL + 1),
    parameter int TW    = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       policy_sel,
    input  logic [6:0]       thr_pct,
    input  logic [NT-1:0]    active_mask,
    input  logic             ins_vld,
    input  logic [TW-1:0]    ins_tid,
    input  logic             rel_vld,
    input  logic [TW-1:0]    rel_tid,
    input  logic             sqr_vld,
    input  logic [TW-1:0]    sqr_tid,
    output logic [NT*CW-1:0] thr_free,
    output logic [NT-1:0]    thr_full,
    output logic             q_full,
    output logic             ovf_err
);
    localparam int SW = CW + 3;

    alloc_state_e  state_q, state_d;
    logic [NT-1:0] mask_q;
    logic [NT*CW-1:0] lim_q, lim_calc;
    logic [NT*CW-1:0] cnt_flat;
    logic [NT*2-1:0]  dec_flat;
    logic [CW-1:0] free_q;
    logic          ins_ok;
    logic [SW-1:0] dec_sum;

    iqa_limit_calc #(.NT(NT), .TOTAL(TOTAL), .CW(CW)) u_calc (
        .policy   (policy_sel),
        .pct      (thr_pct),
        .mask     (active_mask),
        .use_mask (state_q == ST_REBAL),
        .lim_flat (lim_calc)
    );

    assign q_full = (free_q == '0);
    assign ins_ok = ins_vld && !thr_full[ins_tid] && !q_full;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        iqa_thread_ctr #(.CW(CW)) u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .limit     (lim_q[t*CW +: CW]),
            .inc       (ins_ok && ins_tid == TW'(t)),
            .rel       (rel_vld && rel_tid == TW'(t)),
            .sqr       (sqr_vld && sqr_tid == TW'(t)),
            .cnt       (cnt_flat[t*CW +: CW]),
            .free      (thr_free[t*CW +: CW]),
            .full      (thr_full[t]),
            .dec_taken (dec_flat[t*2 +: 2])
        );
    end

    always_comb begin
        dec_sum = '0;
        for (int i = 0; i < NT; i++) begin
            dec_sum = dec_sum + SW'(dec_flat[i*2 +: 2]);
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:  state_d = ST_RUN;
            ST_RUN:   if (active_mask != mask_q) state_d = ST_REBAL;
            ST_REBAL: state_d = ST_RUN;
            default:  state_d = ST_INIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q   <= '0;
            mask_q  <= '0;
            free_q  <= CW'(TOTAL);
            ovf_err <= 1'b0;
        end else begin
            unique case (state_q)
                ST_INIT: begin
                    lim_q  <= lim_calc;
                    mask_q <= active_mask;
                end
                ST_RUN: begin
                    if (active_mask != mask_q) mask_q <= active_mask;
                end
                ST_REBAL: lim_q <= lim_calc;
                default: lim_q <= lim_q;
            endcase
            free_q  <= CW'(SW'(free_q) - SW'(ins_ok) + dec_sum);
            ovf_err <= ins_vld && !ins_ok;
        end
    end
endmodule

// File: rtl/iqa_checker.sv
module iqa_checker #(
    parameter int NT    = 4,
    parameter int TOTAL = 32,
    parameter int CW    = 6,
    parameter int TW    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ins_vld,
    input logic [TW-1:0]    ins_tid,
    input logic [NT-1:0]    thr_full,
    input logic             q_full,
    input logic             ovf_err,
    input logic [CW-1:0]    free_q,
    input logic [NT*CW-1:0] cnt_flat,
    input logic [1:0]       state_q
);
    logic [CW+3:0] cnt_sum;

    always_comb begin
        cnt_sum = '0;
        for (int i = 0; i < NT; i++) begin
            cnt_sum = cnt_sum + (CW+4)'(cnt_flat[i*CW +: CW]);
        end
    end

    assert_free_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (CW+4)'(free_q) + cnt_sum == (CW+4)'(TOTAL));

    assert_qfull_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_vld && q_full) |=> ovf_err);

    assert_thrfull_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_vld && thr_full[ins_tid]) |=> ovf_err);

    assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |-> $past(ins_vld));

    assert_rebal_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == 2'b10) |=> (state_q == 2'b01));
endmodule

bind iqa_alloc iqa_checker #(.NT(NT), .TOTAL(TOTAL), .CW(CW), .TW(TW)) u_iqa_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_vld  (ins_vld),
    .ins_tid  (ins_tid),
    .thr_full (thr_full),
    .q_full   (q_full),
    .ovf_err  (ovf_err),
    .free_q   (free_q),
    .cnt_flat (cnt_flat),
    .state_q  (state_q)
);

// File: tb/test_iqa_alloc.sv
module test_iqa_alloc;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;
    localparam int TOTAL = 32;
    localparam int CW = 6;
    localparam int TW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] policy_sel = 2'b00;
    logic [6:0] thr_pct = 7'd0;
    logic [NT-1:0] active_mask = 4'b1111;
    logic ins_vld = 1'b0, rel_vld = 1'b0, sqr_vld = 1'b0;
    logic [TW-1:0] ins_tid = '0, rel_tid = '0, sqr_tid = '0;
    logic [NT*CW-1:0] thr_free;
    logic [NT-1:0] thr_full;
    logic q_full, ovf_err;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iqa_alloc #(.NT(NT), .TOTAL(TOTAL)) i_iqa_alloc (
        .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .thr_pct(thr_pct),
        .active_mask(active_mask), .ins_vld(ins_vld), .ins_tid(ins_tid),
        .rel_vld(rel_vld), .rel_tid(rel_tid), .sqr_vld(sqr_vld), .sqr_tid(sqr_tid),
        .thr_free(thr_free), .thr_full(thr_full), .q_full(q_full), .ovf_err(ovf_err)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int fr(input int t);
        return int'(thr_free[t*CW +: CW]);
    endfunction

    task automatic do_reset(input logic [1:0] pol, input logic [6:0] pct);
        rst_n = 1'b0;
        policy_sel = pol;
        thr_pct = pct;
        active_mask = 4'b1111;
        ins_vld = 0; rel_vld = 0; sqr_vld = 0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic insert(input int t, input int n);
        for (int i = 0; i < n; i++) begin
            ins_vld = 1'b1;
            ins_tid = TW'(t);
            tick();
        end
        ins_vld = 1'b0;
    endtask

    task automatic set_mask(input logic [NT-1:0] m);
        active_mask = m;
        tick();
        tick();
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        policy_sel = 2'b00;
        active_mask = 4'b1111;
        tick();
        chk("R1 reset free t0", fr(0), 0);
        chk("R1 reset full", int'(thr_full), 15);
        chk("R1 reset q_full", int'(q_full), 0);
        chk("R1 reset ovf_err", int'(ovf_err), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 init loads limit", fr(3), 32);
    endtask

    task automatic t_dynamic();
        do_reset(2'b00, 7'd0);
        chk("R2 dynamic limit", fr(2), 32);
        for (int i = 0; i < 32; i++) begin
            ins_vld = 1'b1;
            ins_tid = TW'(i % 4);
            tick();
        end
        ins_vld = 1'b0;
        chk("R2 free after 8 inserts", fr(1), 24);
        chk("R9 q_full at total", int'(q_full), 1);
        insert(1, 1);
        chk("R10 ovf on full queue", int'(ovf_err), 1);
        chk("R10 rejected insert keeps count", fr(1), 24);
        tick();
        chk("R10 ovf one cycle", int'(ovf_err), 0);
        rel_vld = 1'b1; rel_tid = 2'd1;
        sqr_vld = 1'b1; sqr_tid = 2'd1;
        tick();
        rel_vld = 1'b0; sqr_vld = 1'b0;
        chk("R11 double release", fr(1), 26);
        chk("R9 q_full clears", int'(q_full), 0);
        do_reset(2'b11, 7'd0);
        chk("R2 code 11 is dynamic", fr(0), 32);
    endtask

    task automatic t_partitioned();
        do_reset(2'b01, 7'd0);
        chk("R3 partitioned base", fr(3), 8);
        insert(0, 3);
        chk("R10 insert counts", fr(0), 5);
        ins_vld = 1'b1; ins_tid = 2'd0;
        rel_vld = 1'b1; rel_tid = 2'd0;
        tick();
        ins_vld = 1'b0; rel_vld = 1'b0;
        chk("R12 insert and release cancel", fr(0), 5);
        rel_vld = 1'b1; rel_tid = 2'd3;
        tick();
        rel_vld = 1'b0;
        chk("R11 release on empty ignored", fr(3), 8);
        insert(2, 8);
        chk("R8 thread full", int'(thr_full[2]), 1);
        insert(2, 1);
        chk("R10 ovf on full thread", int'(ovf_err), 1);
        chk("R10 full thread free stays", fr(2), 0);
        set_mask(4'b0011);
        chk("R6 active share t0", fr(0), 13);
        chk("R6 active share t1", fr(1), 16);
        chk("R6 inactive keeps base", fr(3), 8);
        set_mask(4'b0000);
        chk("R6 empty mask base", fr(0), 5);
        set_mask(4'b0111);
        chk("R6 three active t1", fr(1), 10);
        chk("R6 three active t2", fr(2), 2);
        set_mask(4'b0001);
        chk("R5 single active t0", fr(0), 29);
        insert(0, 17);
        set_mask(4'b1111);
        chk("R8 shrink saturates", fr(0), 0);
        chk("R8 shrink full", int'(thr_full[0]), 1);
    endtask

    task automatic t_threshold();
        do_reset(2'b10, 7'd30);
        chk("R4 threshold 30pct", fr(1), 9);
        active_mask = 4'b0100;
        tick();
        chk("R5 not yet rebalanced", fr(2), 9);
        tick();
        chk("R7 single thread gets total", fr(2), 32);
        chk("R7 other thread base", fr(0), 9);
        set_mask(4'b0110);
        chk("R7 two active base", fr(2), 9);
        do_reset(2'b10, 7'd120);
        chk("R4 pct clamp", fr(0), 32);
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_dynamic();
        t_partitioned();
        t_threshold();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule